// File: doc/BRIEF.md
# Interrupt Pending Level Manager

This block collects the interrupt requests of a processor subsystem into a seven-level pending set. It tells the CPU which level to take next. Two sources are edge events that must not be lost: a horizontal-blank pulse at level 2 and a vertical-blank pulse at level 4. Each one sets a sticky bit that stays set until the CPU acknowledges that level. Level 6 is shared by two device request lines. Its pending bit is not sticky. It is refreshed every cycle from the OR of both lines, so if both devices withdraw before service, the request disappears without any acknowledge.

The block holds the status word that carries the interrupt mask in bits 10:8. It raises a request with the highest pending level that is strictly above that mask, together with the matching exception number (level plus 24). When the CPU takes a level-6 interrupt, the block forces the mask field to 6 and leaves the other status bits alone. The block also tracks a stopped state entered by the CPU; taking any interrupt leaves that state.

Every input is registered once, so an output reflects a stimulus one clock edge after that stimulus is sampled.

Top module: `irq_level_mgr`

## Requirements
- R1: After reset the pending set is empty, the status word is 16'h0700 (mask 7), the CPU is not stopped, and irq_req, irq_level and irq_excnum are all 0.
- R2: A one-cycle hblank_pulse sets pending_levels bit 1 (level 2) after the next edge. The bit stays set until an acknowledge names level 2.
- R3: A one-cycle vblank_pulse sets pending_levels bit 3 (level 4) after the next edge. The bit stays set until an acknowledge names level 4.
- R4: pending_levels bit 5 (level 6) equals, one edge later, the OR of dev_a_req and dev_b_req. It clears with no acknowledge when both lines are low.
- R5: An acknowledge clears only the sticky bit of the acknowledged level. It has no effect on level 6, and an acknowledge of a level that is not pending changes nothing.
- R6: An acknowledge of level 6 sets status bits 10:8 to 6 and keeps every other status bit.
- R7: When irq_req is high, irq_level is the highest pending level strictly greater than the mask (status bits 10:8), and irq_excnum equals irq_level + 24. Level 7, if ever pending, is eligible whatever the mask.
- R8: When no pending level is eligible, irq_req, irq_level and irq_excnum are 0, while pending_levels still shows the pending bits.
- R9: stop_req sets cpu_stopped after the next edge. An acknowledge clears it, and an acknowledge wins when it arrives in the same cycle as stop_req.
- R10: When a blank pulse and an acknowledge of the same level arrive in the same cycle, the level stays pending.
- R11: sr_wr_en loads sr_wr_data into the status word after the next edge. If a level-6 acknowledge arrives in the same cycle, the stored word is the written value with bits 10:8 forced to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hblank_pulse | input | 1 | Horizontal-blank event, level 2 |
| vblank_pulse | input | 1 | Vertical-blank event, level 4 |
| dev_a_req | input | 1 | First shared level-6 request line |
| dev_b_req | input | 1 | Second shared level-6 request line |
| ack_valid | input | 1 | CPU takes an interrupt this cycle |
| ack_level | input | 3 | Level being taken |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | 16 | Status word write value |
| stop_req | input | 1 | CPU enters the stopped state |
| pending_levels | output | 7 | Pending set, bit n-1 is level n |
| irq_req | output | 1 | An eligible level is pending |
| irq_level | output | 3 | Level presented to the CPU, 0 when idle |
| irq_excnum | output | 5 | Exception number, level + 24, 0 when idle |
| sr_value | output | 16 | Current status word |
| cpu_stopped | output | 1 | CPU is in the stopped state |

## Verification
Two situations are hard to reach from the ports. One is a level-6 acknowledge while a device line is still high, where the pending bit must survive and the raised mask must hide it. The bench holds dev_a_req high across the acknowledge and then drops it. Same-cycle collisions are the other hard case: a pulse with an acknowledge of its own level, a status write with a level-6 acknowledge, and stop_req with an acknowledge. The bench drives each pair together in a single cycle and reads the result on the next falling edge.

// File: rtl/irq_mgr_pkg.sv
package irq_mgr_pkg;
    localparam int NUM_LEVELS   = 7;
    localparam int LVL_W        = $clog2(NUM_LEVELS + 1);
    localparam int SR_W         = 16;
    localparam int MASK_LSB     = 8;
    localparam int HBL_LEVEL    = 2;
    localparam int VBL_LEVEL    = 4;
    localparam int SHARED_LEVEL = 6;
    localparam int TOP_LEVEL    = NUM_LEVELS;
    localparam int EXC_BASE     = 24;
    localparam int EXC_W        = $clog2(EXC_BASE + NUM_LEVELS + 1);
endpackage

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int NUM_LEVELS   = irq_mgr_pkg::NUM_LEVELS,
    parameter int LVL_W        = irq_mgr_pkg::LVL_W,
    parameter int HBL_LEVEL    = irq_mgr_pkg::HBL_LEVEL,
    parameter int VBL_LEVEL    = irq_mgr_pkg::VBL_LEVEL,
    parameter int SHARED_LEVEL = irq_mgr_pkg::SHARED_LEVEL
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hbl_pulse,
    input  logic                  vbl_pulse,
    input  logic                  dev_a,
    input  logic                  dev_b,
    input  logic                  ack_valid,
    input  logic [LVL_W-1:0]      ack_level,
    output logic [NUM_LEVELS-1:0] pend_o
);
    typedef struct packed {
        logic [NUM_LEVELS-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int lvl = 1; lvl <= NUM_LEVELS; lvl++) begin
            if (lvl == SHARED_LEVEL) begin
                // shared level mirrors its device lines every cycle
                st_d.pend[lvl-1] = dev_a | dev_b;
            end else begin
                if (ack_valid && ack_level == LVL_W'(lvl))
                    st_d.pend[lvl-1] = 1'b0;
                // a fresh event outranks a same-cycle acknowledge
                if ((lvl == HBL_LEVEL && hbl_pulse) || (lvl == VBL_LEVEL && vbl_pulse))
                    st_d.pend[lvl-1] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R2: a latched blank request survives until its own acknowledge
    a_r2_hbl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[HBL_LEVEL-1] && !(ack_valid && ack_level == LVL_W'(HBL_LEVEL)))
        |=> pend_o[HBL_LEVEL-1]);

    // R4: shared level tracks the OR of the device lines
    a_r4_shared_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_o[SHARED_LEVEL-1] == $past(dev_a | dev_b)));

    // R10: event wins over acknowledge of the same level
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_pulse |=> pend_o[VBL_LEVEL-1]);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NUM_LEVELS = irq_mgr_pkg::NUM_LEVELS,
    parameter int LVL_W      = irq_mgr_pkg::LVL_W,
    parameter int TOP_LEVEL  = irq_mgr_pkg::TOP_LEVEL,
    parameter int EXC_BASE   = irq_mgr_pkg::EXC_BASE,
    parameter int EXC_W      = irq_mgr_pkg::EXC_W
) (
    input  logic [NUM_LEVELS-1:0] pend,
    input  logic [LVL_W-1:0]      mask,
    output logic                  req,
    output logic [LVL_W-1:0]      level,
    output logic [EXC_W-1:0]      excnum
);
    logic [NUM_LEVELS-1:0] elig;

    // a level qualifies when it sits above the mask; the top level ignores the mask
    for (genvar g = 1; g <= NUM_LEVELS; g++) begin : g_elig
        assign elig[g-1] = pend[g-1] && ((LVL_W'(g) > mask) || (g == TOP_LEVEL));
    end

    always_comb begin
        level = '0;
        for (int lvl = 1; lvl <= NUM_LEVELS; lvl++) begin
            if (elig[lvl-1]) level = LVL_W'(lvl);
        end
    end

    assign req    = |elig;
    assign excnum = req ? (EXC_W'(EXC_BASE) + EXC_W'(level)) : '0;
endmodule

// File: rtl/irq_status_ctl.sv
module irq_status_ctl #(
    parameter int LVL_W        = irq_mgr_pkg::LVL_W,
    parameter int SR_W         = irq_mgr_pkg::SR_W,
    parameter int MASK_LSB     = irq_mgr_pkg::MASK_LSB,
    parameter int SHARED_LEVEL = irq_mgr_pkg::SHARED_LEVEL,
    parameter int TOP_LEVEL    = irq_mgr_pkg::TOP_LEVEL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SR_W-1:0]  wr_data,
    input  logic             stop_req,
    input  logic             take_valid,
    input  logic [LVL_W-1:0] take_level,
    output logic [SR_W-1:0]  sr_o,
    output logic             stopped_o
);
    localparam logic [SR_W-1:0] SR_RESET = SR_W'(TOP_LEVEL) << MASK_LSB;

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            stopped;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.sr = wr_data;
        if (take_valid && take_level == LVL_W'(SHARED_LEVEL))
            st_d.sr[MASK_LSB +: LVL_W] = LVL_W'(SHARED_LEVEL);
        if (stop_req)   st_d.stopped = 1'b1;
        if (take_valid) st_d.stopped = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr      <= SR_RESET;
            st_q.stopped <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_o      = st_q.sr;
    assign stopped_o = st_q.stopped;

    // R6: taking the shared level raises the mask to that level
    a_r6_mask_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_level == LVL_W'(SHARED_LEVEL))
        |=> (sr_o[MASK_LSB +: LVL_W] == LVL_W'(SHARED_LEVEL)));

    // R9: an interrupt taken always leaves the stopped state
    a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |=> !stopped_o);
endmodule

// File: rtl/irq_level_mgr.sv
module irq_level_mgr #(
    parameter int NUM_LEVELS   = irq_mgr_pkg::NUM_LEVELS,
    parameter int LVL_W        = irq_mgr_pkg::LVL_W,
    parameter int SR_W         = irq_mgr_pkg::SR_W,
    parameter int MASK_LSB     = irq_mgr_pkg::MASK_LSB,
    parameter int EXC_W        = irq_mgr_pkg::EXC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hblank_pulse,
    input  logic                  vblank_pulse,
    input  logic                  dev_a_req,
    input  logic                  dev_b_req,
    input  logic                  ack_valid,
    input  logic [LVL_W-1:0]      ack_level,
    input  logic                  sr_wr_en,
    input  logic [SR_W-1:0]       sr_wr_data,
    input  logic                  stop_req,
    output logic [NUM_LEVELS-1:0] pending_levels,
    output logic                  irq_req,
    output logic [LVL_W-1:0]      irq_level,
    output logic [EXC_W-1:0]      irq_excnum,
    output logic [SR_W-1:0]       sr_value,
    output logic                  cpu_stopped
);
    localparam int TOP = irq_mgr_pkg::TOP_LEVEL;

    logic [LVL_W-1:0] cur_mask;

    irq_pend_latch #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .hbl_pulse (hblank_pulse),
        .vbl_pulse (vblank_pulse),
        .dev_a     (dev_a_req),
        .dev_b     (dev_b_req),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .pend_o    (pending_levels)
    );

    irq_status_ctl #(.LVL_W(LVL_W), .SR_W(SR_W), .MASK_LSB(MASK_LSB)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (sr_wr_en),
        .wr_data    (sr_wr_data),
        .stop_req   (stop_req),
        .take_valid (ack_valid),
        .take_level (ack_level),
        .sr_o       (sr_value),
        .stopped_o  (cpu_stopped)
    );

    assign cur_mask = sr_value[MASK_LSB +: LVL_W];

    irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .EXC_W(EXC_W)) u_enc (
        .pend   (pending_levels),
        .mask   (cur_mask),
        .req    (irq_req),
        .level  (irq_level),
        .excnum (irq_excnum)
    );

    // R7: a presented level is pending and above the mask
    a_r7_level_valid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_level != '0) && pending_levels[irq_level - 1'b1]
                    && ((irq_level > cur_mask) || (irq_level == LVL_W'(TOP))));

    // R8: an empty pending set never raises a request
    a_r8_quiet_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_levels == '0) |-> (!irq_req && irq_excnum == '0));
endmodule

// File: tb/irq_level_mgr_test.sv
module irq_level_mgr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hblank_pulse = 0, vblank_pulse = 0, dev_a_req = 0, dev_b_req = 0;
    logic        ack_valid = 0, sr_wr_en = 0, stop_req = 0;
    logic [2:0]  ack_level = '0;
    logic [15:0] sr_wr_data = '0;
    logic [6:0]  pending_levels;
    logic        irq_req, cpu_stopped;
    logic [2:0]  irq_level;
    logic [4:0]  irq_excnum;
    logic [15:0] sr_value;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_level_mgr uut (
        .clk(clk), .rst_n(rst_n), .hblank_pulse(hblank_pulse), .vblank_pulse(vblank_pulse),
        .dev_a_req(dev_a_req), .dev_b_req(dev_b_req), .ack_valid(ack_valid), .ack_level(ack_level),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .stop_req(stop_req),
        .pending_levels(pending_levels), .irq_req(irq_req), .irq_level(irq_level),
        .irq_excnum(irq_excnum), .sr_value(sr_value), .cpu_stopped(cpu_stopped)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic write_sr(input logic [15:0] v);
        sr_wr_en = 1; sr_wr_data = v; tick(); sr_wr_en = 0;
        chk("R11 sr write", 32'(sr_value), 32'(v));
    endtask

    task automatic ack(input logic [2:0] l);
        ack_valid = 1; ack_level = l; tick(); ack_valid = 0;
    endtask

    task automatic t_reset();
        chk("R1 pending", 32'(pending_levels), 0);
        chk("R1 sr", 32'(sr_value), 32'h0700);
        chk("R1 stopped", 32'(cpu_stopped), 0);
        chk("R1 req", 32'(irq_req), 0);
        chk("R1 excnum", 32'(irq_excnum), 0);
    endtask

    task automatic t_blank();
        write_sr(16'h2000);
        hblank_pulse = 1; tick(); hblank_pulse = 0;
        chk("R2 hbl latched", 32'(pending_levels), 32'h02);
        chk("R7 level2", 32'(irq_level), 2);
        chk("R7 exc26", 32'(irq_excnum), 26);
        repeat (3) tick();
        chk("R2 hbl held", 32'(pending_levels), 32'h02);
        vblank_pulse = 1; tick(); vblank_pulse = 0;
        chk("R3 vbl latched", 32'(pending_levels), 32'h0A);
        chk("R7 level4", 32'(irq_level), 4);
        chk("R7 exc28", 32'(irq_excnum), 28);
        ack(3'd2);
        chk("R5 only level2 cleared", 32'(pending_levels), 32'h08);
        chk("R3 level4 shown", 32'(irq_level), 4);
        ack(3'd4);
        chk("R3 vbl cleared", 32'(pending_levels), 0);
        chk("R8 req idle", 32'(irq_req), 0);
        chk("R8 level idle", 32'(irq_level), 0);
    endtask

    task automatic t_mask();
        write_sr(16'h0300);
        hblank_pulse = 1; tick(); hblank_pulse = 0;
        chk("R8 masked pending kept", 32'(pending_levels), 32'h02);
        chk("R8 masked req", 32'(irq_req), 0);
        write_sr(16'h0100);
        chk("R7 unmasked req", 32'(irq_req), 1);
        chk("R7 unmasked level", 32'(irq_level), 2);
        write_sr(16'h0200);
        chk("R7 equal mask blocks", 32'(irq_req), 0);
        ack(3'd2);
        chk("R2 ack clears", 32'(pending_levels), 0);
    endtask

    task automatic t_shared();
        write_sr(16'h0000);
        dev_a_req = 1; tick();
        chk("R4 dev a", 32'(pending_levels), 32'h20);
        chk("R7 exc30", 32'(irq_excnum), 30);
        dev_a_req = 0; dev_b_req = 1; tick();
        chk("R4 dev b", 32'(pending_levels), 32'h20);
        hblank_pulse = 1; tick(); hblank_pulse = 0;
        chk("R7 six over two", 32'(irq_level), 6);
        ack(3'd2);
        chk("R5 ack2 spares six", 32'(pending_levels), 32'h20);
        dev_b_req = 0; tick();
        chk("R4 withdrawn", 32'(pending_levels), 0);
        chk("R8 withdrawn req", 32'(irq_req), 0);
    endtask

    task automatic t_ack_shared();
        write_sr(16'h2100);
        dev_a_req = 1; tick();
        ack(3'd6);
        chk("R6 mask forced", 32'(sr_value), 32'h2600);
        chk("R5 ack6 keeps six", 32'(pending_levels), 32'h20);
        chk("R7 six hidden by mask", 32'(irq_req), 0);
        dev_a_req = 0; tick();
        chk("R4 cleared no ack", 32'(pending_levels), 0);
    endtask

    task automatic t_collide();
        write_sr(16'h0000);
        hblank_pulse = 1; tick();
        ack_valid = 1; ack_level = 3'd2; tick();
        hblank_pulse = 0; ack_valid = 0;
        chk("R10 pulse beats ack", 32'(pending_levels), 32'h02);
        ack(3'd2);
        chk("R10 later ack clears", 32'(pending_levels), 0);
    endtask

    task automatic t_stop();
        stop_req = 1; tick(); stop_req = 0;
        chk("R9 stopped", 32'(cpu_stopped), 1);
        tick();
        chk("R9 stays stopped", 32'(cpu_stopped), 1);
        ack(3'd3);
        chk("R9 woken", 32'(cpu_stopped), 0);
        chk("R5 ack absent level", 32'(pending_levels), 0);
        chk("R5 ack3 sr kept", 32'(sr_value), 32'h0000);
        stop_req = 1; ack_valid = 1; ack_level = 3'd2; tick();
        stop_req = 0; ack_valid = 0;
        chk("R9 ack wins", 32'(cpu_stopped), 0);
    endtask

    task automatic t_write_ack();
        sr_wr_en = 1; sr_wr_data = 16'h8001; ack_valid = 1; ack_level = 3'd6; tick();
        sr_wr_en = 0; ack_valid = 0;
        chk("R11 write with ack6", 32'(sr_value), 32'h8601);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_blank();
        t_mask();
        t_shared();
        t_ack_shared();
        t_collide();
        t_stop();
        t_write_ack();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule